// File: doc/BRIEF.md
# Root Hub Port Status and Control Registers

This block holds the 16-bit status and control word for each downstream port of a full-speed host controller's root hub. Software reaches the words through a window of eight word slots; slot n addresses port n, and slots with no port behind them read back a fixed pattern that software takes to mean "no port here". Each word mixes three kinds of bits: bits that only hardware changes, bits that software writes directly, and change flags that software clears by writing a one.

Hardware events come in from the port side. A device attaching carries a low-speed indication, and a device can also detach. The block records these in the connect, change and speed bits. It drives the enable bit out to the transfer scheduler. It issues a one-cycle bus-reset request when software raises the port-reset bit while a device is present. It also issues a one-cycle resume request to the controller whenever a port event occurs while the controller's global-suspend command is active. The controller uses that request to set its force-resume command bit and its resume-detect status bit.

Top module: `hub_port_regs`

## Requirements
- R1: After reset every implemented port word reads 0x0080, and bus_reset_o, resume_o and port_en_o are all zero. Bit 7 always reads 1 and bits 6..4 always read 0.
- R2: A write to an implemented slot replaces bit 2 (enable), bit 9 (port reset) and bits 15..10 with the written value. Bits 0 (connected), 1 (connect changed), 3 (enable changed) and 8..4 keep their prior value. The new word is visible on the cycle after the write edge.
- R3: In the same write, a 1 written to bit 1 or bit 3 clears that bit. A 0 written there leaves it unchanged.
- R4: An attach event sets bit 0 and bit 1 and loads bit 8 with low_speed_i (1 means a low-speed device).
- R5: A detach event clears bit 0 and sets bit 1 if bit 0 was set. It clears bit 2 and sets bit 3 if bit 2 is set once any same-cycle write has been applied. Otherwise it leaves those bits unchanged.
- R6: When an attach or detach on a port coincides with a software write to that port, the event's effect on bits 0–3 and 8 is applied over the write's result. For example, an attach wins over a same-cycle write-1-to-clear of bit 1.
- R7: bus_reset_o[n] is high for exactly the one cycle after a write to slot n that writes bit 9 as 1 while bit 9 was 0 and bit 0 was 1. In all other cycles it is low.
- R8: resume_o is high for exactly the one cycle after a cycle in which suspend_i was 1 and any port had an attach or detach event. It is low in every other cycle.
- R9: rd_data_o shows, combinationally, the word of port slot_i when slot_i < NUM_PORTS, and 0xFF7F otherwise.
- R10: port_en_o[n] always equals bit 2 of port n's word.
- R11: Writes to slots at or above NUM_PORTS change no port word and produce no bus-reset pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slot_i | input | 3 | Word slot selected for read and write |
| wr_en_i | input | 1 | Write strobe for the selected slot |
| wr_data_i | input | 16 | Write data |
| rd_data_o | output | 16 | Read data of the selected slot |
| attach_i | input | NUM_PORTS | Per-port device attach event (one cycle) |
| detach_i | input | NUM_PORTS | Per-port device detach event (one cycle) |
| low_speed_i | input | NUM_PORTS | Speed of the attaching device, 1 = low speed |
| suspend_i | input | 1 | Controller global-suspend command bit |
| port_en_o | output | NUM_PORTS | Port enable, to the scheduler |
| bus_reset_o | output | NUM_PORTS | One-cycle bus-reset request to the device |
| resume_o | output | 1 | One-cycle resume request to the controller |

## Verification
The assertions take for granted that attach and detach are never both raised for the same port in the same cycle, and one of them checks that assumption at the inputs. They also expect reset to last at least one clock before events start. The stimulus draws its events so that a port sees at most one of the two per cycle and holds all events low during reset. Beyond that, it deliberately lines events up with writes to the same slot, with write-1-to-clear data and with suspend, so the priority and pulse rules are exercised at their edges.

// File: rtl/hub_port_pkg.sv
package hub_port_pkg;

    localparam int WORD_W = 16;
    localparam int SLOT_W = 3;
    localparam int SLOTS  = 1 << SLOT_W;

    // bit positions decoded by software drivers
    localparam int B_CONN     = 0;
    localparam int B_CONN_CHG = 1;
    localparam int B_EN       = 2;
    localparam int B_EN_CHG   = 3;
    localparam int B_LOWSPD   = 8;
    localparam int B_BUSRST   = 9;

    localparam logic [WORD_W-1:0] PORT_RESET_WORD = 16'h0080;
    localparam logic [WORD_W-1:0] HW_KEEP_MASK    = 16'h01FB;
    localparam logic [WORD_W-1:0] CHG_CLEAR_MASK  = 16'h000A;
    localparam logic [WORD_W-1:0] ABSENT_WORD     = 16'hFF7F;

    typedef logic [WORD_W-1:0] port_word_t;

    typedef enum logic [1:0] {
        EVT_NONE   = 2'd0,
        EVT_ATTACH = 2'd1,
        EVT_DETACH = 2'd2
    } port_evt_e;

    typedef struct packed {
        port_evt_e kind;
        logic      low_speed;
    } port_evt_t;

    function automatic port_evt_t classify_evt(input logic att, input logic det,
                                               input logic ls);
        port_evt_t e;
        e.low_speed = ls;
        if (att)      e.kind = EVT_ATTACH;
        else if (det) e.kind = EVT_DETACH;
        else          e.kind = EVT_NONE;
        return e;
    endfunction

    function automatic port_word_t merge_sw_write(input port_word_t cur,
                                                  input port_word_t wd);
        port_word_t m;
        m = (cur & HW_KEEP_MASK) | (wd & ~HW_KEEP_MASK);
        m = m & ~(wd & CHG_CLEAR_MASK);
        return m;
    endfunction

endpackage

// File: rtl/hub_port_cell.sv
module hub_port_cell
    import hub_port_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_hit,
    input  port_word_t wr_data,
    input  port_evt_t  evt,
    output port_word_t word_o,
    output logic       bus_reset_o
);
    port_word_t word_q, after_wr, word_d;
    logic       brst_q, brst_d;

    always_comb begin
        after_wr = word_q;
        if (wr_hit) after_wr = merge_sw_write(word_q, wr_data);
        word_d = after_wr;
        unique case (evt.kind)
            EVT_ATTACH: begin
                word_d[B_CONN]     = 1'b1;
                word_d[B_CONN_CHG] = 1'b1;
                word_d[B_LOWSPD]   = evt.low_speed;
            end
            EVT_DETACH: begin
                if (after_wr[B_CONN]) begin
                    word_d[B_CONN]     = 1'b0;
                    word_d[B_CONN_CHG] = 1'b1;
                end
                if (after_wr[B_EN]) begin
                    word_d[B_EN]     = 1'b0;
                    word_d[B_EN_CHG] = 1'b1;
                end
            end
            default: ;
        endcase
    end

    // rising edge of the port-reset bit with a device present
    always_comb begin
        brst_d = wr_hit && wr_data[B_BUSRST] && !word_q[B_BUSRST] && word_q[B_CONN];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= PORT_RESET_WORD;
            brst_q <= 1'b0;
        end else begin
            word_q <= word_d;
            brst_q <= brst_d;
        end
    end

    assign word_o      = word_q;
    assign bus_reset_o = brst_q;
endmodule

// File: rtl/hub_port_rdmux.sv
module hub_port_rdmux
    import hub_port_pkg::*;
#(
    parameter int NUM_PORTS = 2
)(
    input  logic [SLOT_W-1:0]        slot_i,
    input  port_word_t [NUM_PORTS-1:0] words_i,
    output port_word_t               rd_data_o
);
    port_word_t slot_word [SLOTS];

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        if (s < NUM_PORTS) begin : g_real
            assign slot_word[s] = words_i[s];
        end else begin : g_absent
            assign slot_word[s] = ABSENT_WORD;
        end
    end

    assign rd_data_o = slot_word[slot_i];
endmodule

// File: rtl/hub_port_resume.sv
module hub_port_resume #(
    parameter int NUM_PORTS = 2
)(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 suspend_i,
    input  logic [NUM_PORTS-1:0] attach_i,
    input  logic [NUM_PORTS-1:0] detach_i,
    output logic                 resume_o
);
    logic any_evt, res_q;

    assign any_evt = |(attach_i | detach_i);

    always_ff @(posedge clk) begin
        if (rst) res_q <= 1'b0;
        else     res_q <= suspend_i && any_evt;
    end

    assign resume_o = res_q;
endmodule

// File: rtl/hub_port_regs.sv
module hub_port_regs
    import hub_port_pkg::*;
#(
    parameter int NUM_PORTS = 2
)(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [2:0]           slot_i,
    input  logic                 wr_en_i,
    input  logic [15:0]          wr_data_i,
    output logic [15:0]          rd_data_o,
    input  logic [NUM_PORTS-1:0] attach_i,
    input  logic [NUM_PORTS-1:0] detach_i,
    input  logic [NUM_PORTS-1:0] low_speed_i,
    input  logic                 suspend_i,
    output logic [NUM_PORTS-1:0] port_en_o,
    output logic [NUM_PORTS-1:0] bus_reset_o,
    output logic                 resume_o
);
    port_word_t [NUM_PORTS-1:0] port_word;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        logic      hit;
        port_evt_t evt;
        assign hit = wr_en_i && (slot_i == SLOT_W'(p));
        assign evt = classify_evt(attach_i[p], detach_i[p], low_speed_i[p]);

        hub_port_cell u_cell (
            .clk         (clk),
            .rst         (rst),
            .wr_hit      (hit),
            .wr_data     (wr_data_i),
            .evt         (evt),
            .word_o      (port_word[p]),
            .bus_reset_o (bus_reset_o[p])
        );
        assign port_en_o[p] = port_word[p][B_EN];
    end

    hub_port_rdmux #(.NUM_PORTS(NUM_PORTS)) u_rdmux (
        .slot_i    (slot_i),
        .words_i   (port_word),
        .rd_data_o (rd_data_o)
    );

    hub_port_resume #(.NUM_PORTS(NUM_PORTS)) u_resume (
        .clk       (clk),
        .rst       (rst),
        .suspend_i (suspend_i),
        .attach_i  (attach_i),
        .detach_i  (detach_i),
        .resume_o  (resume_o)
    );
endmodule

// File: rtl/hub_port_regs_chk.sv
module hub_port_regs_chk #(
    parameter int NUM_PORTS = 2
)(
    input logic                        clk,
    input logic                        rst,
    input logic [NUM_PORTS-1:0]        attach_i,
    input logic [NUM_PORTS-1:0]        detach_i,
    input logic [NUM_PORTS-1:0]        low_speed_i,
    input logic                        suspend_i,
    input logic [NUM_PORTS-1:0]        bus_reset_o,
    input logic                        resume_o,
    input logic [NUM_PORTS-1:0][15:0]  port_word
);
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_chk
        assert_evt_exclusive_R5: assert property (@(posedge clk) disable iff (rst)
            !(attach_i[p] && detach_i[p]));
        assert_fixed_bits_R1: assert property (@(posedge clk) disable iff (rst)
            port_word[p][7] && (port_word[p][6:4] == 3'b000));
        assert_attach_sets_R4: assert property (@(posedge clk) disable iff (rst)
            attach_i[p] |=> (port_word[p][0] && port_word[p][1]
                             && (port_word[p][8] == $past(low_speed_i[p]))));
        assert_detach_clears_R5: assert property (@(posedge clk) disable iff (rst)
            detach_i[p] |=> (!port_word[p][0] && !port_word[p][2]));
        assert_busrst_bit_R7: assert property (@(posedge clk) disable iff (rst)
            bus_reset_o[p] |-> port_word[p][9]);
        assert_busrst_single_R7: assert property (@(posedge clk) disable iff (rst)
            bus_reset_o[p] |=> !bus_reset_o[p]);
    end

    assert_resume_cause_R8: assert property (@(posedge clk) disable iff (rst)
        resume_o |-> $past(suspend_i && |(attach_i | detach_i)));
endmodule

bind hub_port_regs hub_port_regs_chk #(.NUM_PORTS(NUM_PORTS)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .attach_i    (attach_i),
    .detach_i    (detach_i),
    .low_speed_i (low_speed_i),
    .suspend_i   (suspend_i),
    .bus_reset_o (bus_reset_o),
    .resume_o    (resume_o),
    .port_word   (port_word)
);

// File: tb/tb_hub_port_regs.sv
`timescale 1ns/1ps
module tb_hub_port_regs;
    localparam int NP = 2;

    logic          clk = 1'b0;
    logic          rst;
    logic [2:0]    slot;
    logic          wr_en;
    logic [15:0]   wr_data;
    logic [15:0]   rd_data;
    logic [NP-1:0] attach, detach, low_speed;
    logic          suspend;
    logic [NP-1:0] port_en, bus_reset;
    logic          resume;

    always #4 clk = ~clk;

    hub_port_regs #(.NUM_PORTS(NP)) dut (
        .clk(clk), .rst(rst), .slot_i(slot), .wr_en_i(wr_en), .wr_data_i(wr_data),
        .rd_data_o(rd_data), .attach_i(attach), .detach_i(detach),
        .low_speed_i(low_speed), .suspend_i(suspend), .port_en_o(port_en),
        .bus_reset_o(bus_reset), .resume_o(resume)
    );

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // reference state
    logic [15:0]   mreg [NP];
    logic [NP-1:0] m_brst;
    logic          m_res;

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_read(logic [2:0] s);
        if (int'(s) < NP) return mreg[s];
        return 16'hFF7F;
    endfunction

    task automatic compare_all(string tag);
        logic [NP-1:0] en_exp;
        for (int p = 0; p < NP; p++) en_exp[p] = mreg[p][2];
        chk({tag, "/R9 read"}, rd_data, exp_read(slot));
        chk({tag, "/R10 enable"}, 16'(port_en), 16'(en_exp));
        chk({tag, "/R7 bus reset"}, 16'(bus_reset), 16'(m_brst));
        chk({tag, "/R8 resume"}, 16'(resume), 16'(m_res));
    endtask

    // one clock: inputs applied after the falling edge, results checked after the rising edge
    task automatic step(string tag, logic w, logic [2:0] s, logic [15:0] d,
                        logic [NP-1:0] att, logic [NP-1:0] det,
                        logic [NP-1:0] ls, logic susp);
        logic [15:0]   nxt [NP];
        logic [NP-1:0] nb;
        logic          nr;
        wr_en = w; slot = s; wr_data = d;
        attach = att; detach = det; low_speed = ls; suspend = susp;
        #1;
        chk({tag, "/R9 pre-read"}, rd_data, exp_read(s));
        nb = '0;
        for (int p = 0; p < NP; p++) begin
            nxt[p] = mreg[p];
            if (w && int'(s) == p) begin
                nxt[p][2]     = d[2];
                nxt[p][9]     = d[9];
                nxt[p][15:10] = d[15:10];
                if (d[1]) nxt[p][1] = 1'b0;
                if (d[3]) nxt[p][3] = 1'b0;
                nb[p] = d[9] && !mreg[p][9] && mreg[p][0];
            end
            if (att[p]) begin
                nxt[p][0] = 1'b1;
                nxt[p][1] = 1'b1;
                nxt[p][8] = ls[p];
            end else if (det[p]) begin
                if (nxt[p][0]) begin nxt[p][0] = 1'b0; nxt[p][1] = 1'b1; end
                if (nxt[p][2]) begin nxt[p][2] = 1'b0; nxt[p][3] = 1'b1; end
            end
        end
        nr = susp && ((att | det) != '0);
        @(posedge clk);
        #1;
        for (int p = 0; p < NP; p++) mreg[p] = nxt[p];
        m_brst = nb;
        m_res  = nr;
        compare_all(tag);
        @(negedge clk);
    endtask

    task automatic idle(string tag, logic [2:0] s);
        step(tag, 1'b0, s, 16'h0000, '0, '0, '0, 1'b0);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; slot = '0; wr_en = 0; wr_data = '0;
        attach = '0; detach = '0; low_speed = '0; suspend = 0;
        for (int p = 0; p < NP; p++) mreg[p] = 16'h0080;
        m_brst = '0; m_res = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        #1;
        for (int s = 0; s < NP; s++) begin
            slot = 3'(s); #1;
            chk("R1 reset word", rd_data, 16'h0080);
        end
        chk("R1 reset outputs", {13'd0, resume, bus_reset}, 16'h0000);
        @(negedge clk);

        // R9 absent slots
        for (int s = NP; s < 8; s++) begin
            slot = 3'(s); #1;
            chk("R9 absent slot", rd_data, 16'hFF7F);
        end
        @(negedge clk);

        // R2 write all ones with no device: no reset pulse
        step("R2 write ones", 1, 0, 16'hFFFF, '0, '0, '0, 0);
        chk("R2 merged word", rd_data, 16'hFE84);
        step("R2 write zeros", 1, 0, 16'h0000, '0, '0, '0, 0);
        chk("R2 zero word", rd_data, 16'h0080);

        // R4 low-speed attach
        step("R4 attach low", 0, 0, 16'h0000, 2'b01, '0, 2'b01, 0);
        chk("R4 attach word", rd_data, 16'h0183);

        // R7 reset edge with device present
        step("R7 reset rise", 1, 0, 16'h0204, '0, '0, '0, 0);
        chk("R7 pulse", 16'(bus_reset), 16'h0001);
        step("R7 reset held", 1, 0, 16'h0204, '0, '0, '0, 0);
        chk("R7 no pulse on held bit", 16'(bus_reset), 16'h0000);

        // R3 clear connect change only
        step("R3 clear conn chg", 1, 0, 16'h0006, '0, '0, '0, 0);
        chk("R3 word", rd_data, 16'h0185);

        // R5 and R8 detach while suspended
        step("R5 detach susp", 0, 0, 16'h0000, '0, 2'b01, '0, 1);
        chk("R5 detach word", rd_data, 16'h018A);
        chk("R8 resume pulse", 16'(resume), 16'h0001);
        idle("R8 resume drop", 0);
        chk("R8 one cycle", 16'(resume), 16'h0000);
        step("R3 clear both", 1, 0, 16'h000A, '0, '0, '0, 0);
        chk("R3 both cleared", rd_data, 16'h0180);

        // R6 attach beats same-cycle clear of bit 1
        step("R6 attach vs clear", 1, 1, 16'h0002, 2'b10, '0, 2'b00, 0);
        chk("R6 attach wins", rd_data, 16'h0083);
        chk("R8 no resume when awake", 16'(resume), 16'h0000);

        // R6/R5 detach after same-cycle enable write
        step("R6 detach vs enable", 1, 1, 16'h0004, '0, 2'b10, '0, 0);
        chk("R5 enable change", rd_data, 16'h008A);

        // R11 writes to absent slot change nothing
        step("R11 absent write", 1, 5, 16'hFFFF, '0, '0, '0, 0);
        idle("R11 port0", 0);
        chk("R11 port0 untouched", rd_data, 16'h0180);
        idle("R11 port1", 1);
        chk("R11 port1 untouched", rd_data, 16'h008A);

        // R8 attach while suspended on port 1
        step("R8 attach susp", 0, 1, 16'h0000, 2'b10, '0, 2'b10, 1);
        chk("R8 resume on attach", 16'(resume), 16'h0001);

        // mixed stream
        for (int i = 0; i < 3000; i++) begin
            logic [NP-1:0] a, d;
            logic [15:0] wd;
            a = '0; d = '0;
            for (int p = 0; p < NP; p++) begin
                int r;
                r = $urandom_range(0, 9);
                if (r == 0) a[p] = 1'b1;
                else if (r == 1) d[p] = 1'b1;
            end
            wd = 16'($urandom);
            if ($urandom_range(0, 1) == 1) wd[9] = ~mreg[0][9];
            step("R2 R3 R5 R6 R7 mixed", ($urandom_range(0, 2) != 0),
                 3'($urandom_range(0, 3)), wd, a, d,
                 NP'($urandom), ($urandom_range(0, 3) == 0));
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule